// File: doc/BRIEF.md
# Elastic Parity-Halving Stage

This block is one elastic pipeline stage. It sits between a producer and a consumer, and it changes each word as it passes. An odd word becomes zero. An even word is halved, which is a logical right shift by one.

Both sides use a valid/retry handshake. The sender drives valid and the data. The receiver drives retry to hold the sender back. A word moves on a rising clock edge where valid is high and retry is low. While retry is high, the sender must keep valid high and the data unchanged until the transfer completes.

The stage stores up to two words. The main entry drives the output, and a skid entry catches the word that arrives in the cycle downstream retry rises. Upstream retry comes straight from a register, so there is no combinational path from the consumer's retry to the producer's retry. With downstream retry held low, the stage passes one word per clock with one cycle of latency.

Top module: `parity_halve_stage`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) the stage is empty: `out_valid` is 0 and `in_retry` is 0.
- R2: An input word is taken on a rising edge with `in_valid`=1 and `in_retry`=0. An output word is delivered on a rising edge with `out_valid`=1 and `out_retry`=0.
- R3: When an accepted input word is odd (bit 0 equal to 1), its output word is all zeros.
- R4: When an accepted input word is even (bit 0 equal to 0), its output word is the input shifted right by one, with a 0 in the top bit.
- R5: Words leave in the order they were accepted, and no word is lost or duplicated under any pattern of valid and retry.
- R6: While `out_valid`=1 and `out_retry`=1, the next cycle keeps `out_valid`=1 and `out_data` unchanged.
- R7: `in_retry` comes only from registered state. It rises only after a cycle in which `out_retry` was high. It is high exactly while two words are stored, so the stage accepts one more word after downstream retry rises and then asserts `in_retry`.
- R8: A word accepted into the empty stage appears on `out_valid`/`out_data` in the next cycle.
- R9: While `out_retry` is held at 0, the stage accepts and delivers one word per cycle and never asserts `in_retry`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_data | input | W | Input word (W defaults to 16) |
| in_retry | output | 1 | Stage cannot take a word this cycle |
| out_valid | output | 1 | Stage has a word on `out_data` |
| out_data | output | W | Transformed output word |
| out_retry | input | 1 | Consumer cannot take a word this cycle |

## Verification
The checker assumes the producer keeps its rules: once it raises `in_valid` while `in_retry` is high, it holds `in_valid` and `in_data` until the word is taken. It also assumes `rst` is applied before any traffic. The bench drives every input at the falling edge. It tracks a pending flag for each offered word, so a refused word is always offered again unchanged. It also brings `rst` up for several cycles at the start. The consumer's retry comes from deterministic patterns, including a long stall. `out_retry` is free to change on any cycle, because the stage places no rule on it.

// File: rtl/phs_pkg.sv
package phs_pkg;
  localparam int unsigned PHS_WIDTH_DEFAULT = 16;

  // Number of words held by the stage
  typedef enum logic [1:0] {
    OCC_EMPTY = 2'd0,
    OCC_MAIN  = 2'd1,
    OCC_BOTH  = 2'd2
  } occ_t;
endpackage

// File: rtl/phs_transform.sv
module phs_transform #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  localparam int unsigned TOP = W - 1;

  generate
    if (W == 1) begin : g_narrow
      // a single-bit even word halves to zero, an odd one maps to zero
      assign word_o = '0;
    end else begin : g_wide
      always_comb begin
        if (word_i[0]) word_o = '0;
        else           word_o = {1'b0, word_i[TOP:1]};
      end
    end
  endgenerate
endmodule

// File: rtl/phs_skid_buffer.sv
module phs_skid_buffer
  import phs_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  input  logic [W-1:0] up_word,
  output logic         up_retry,
  output logic         dn_valid,
  output logic [W-1:0] dn_word,
  input  logic         dn_retry
);
  occ_t         occ_q;
  logic [W-1:0] main_q;
  logic [W-1:0] skid_q;
  logic         take;
  logic         give;

  assign up_retry = (occ_q == OCC_BOTH);
  assign dn_valid = (occ_q != OCC_EMPTY);
  assign dn_word  = main_q;
  assign take     = up_valid && !up_retry;
  assign give     = dn_valid && !dn_retry;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q <= OCC_EMPTY;
    end else begin
      unique case (occ_q)
        OCC_EMPTY: if (take) occ_q <= OCC_MAIN;
        OCC_MAIN: begin
          if (!give && take)      occ_q <= OCC_BOTH;
          else if (give && !take) occ_q <= OCC_EMPTY;
        end
        OCC_BOTH: if (give) occ_q <= OCC_MAIN;
        default: occ_q <= OCC_EMPTY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    unique case (occ_q)
      OCC_EMPTY: if (take) main_q <= up_word;
      OCC_MAIN: begin
        if (give && take)       main_q <= up_word;
        else if (!give && take) skid_q <= up_word;
      end
      OCC_BOTH: if (give) main_q <= skid_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/parity_halve_stage.sv
module parity_halve_stage
  import phs_pkg::*;
#(
  parameter int unsigned W = PHS_WIDTH_DEFAULT
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_retry,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_retry
);
  logic [W-1:0] shaped;

  // transform on entry so both storage entries hold finished words
  phs_transform #(.W(W)) u_xform (
    .word_i (in_data),
    .word_o (shaped)
  );

  phs_skid_buffer #(.W(W)) u_buf (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_word  (shaped),
    .up_retry (in_retry),
    .dn_valid (out_valid),
    .dn_word  (out_data),
    .dn_retry (out_retry)
  );
endmodule

// File: rtl/parity_halve_stage_chk.sv
module parity_halve_stage_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [W-1:0] in_data,
  input logic         in_retry,
  input logic         out_valid,
  input logic [W-1:0] out_data,
  input logic         out_retry
);
  logic rst_seen = 1'b0;
  logic rst_prev = 1'b0;

  always_ff @(posedge clk) begin
    rst_prev <= rst;
    if (rst) rst_seen <= 1'b1;
  end

  // R1: the cycle after reset releases, the stage is empty
  always_ff @(posedge clk) begin
    if (rst_prev && !rst) begin
      assert_empty_after_reset_R1: assert (!out_valid && !in_retry);
    end
  end

  // R6: a stalled output word holds
  assert_hold_on_stall_R6: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    (out_valid && out_retry) |=> (out_valid && $stable(out_data)));

  // R4: a halved or zero word never has its top bit set
  assert_top_bit_clear_R4: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    out_valid |-> !out_data[W-1]);

  // R7: retry upstream only rises after downstream retry
  assert_retry_cause_R7: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    $rose(in_retry) |-> $past(out_retry));

  // R7: upstream retry implies a stored word on the output
  assert_retry_needs_data_R7: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    in_retry |-> out_valid);

  // R9: with no downstream retry, no upstream retry next cycle
  assert_no_retry_free_flow_R9: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    !out_retry |=> !in_retry);

  // R2: producer holds a refused word (input assumption)
  assert_sender_holds_R2: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    (in_valid && in_retry) |=> (in_valid && $stable(in_data)));
endmodule

bind parity_halve_stage parity_halve_stage_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_retry  (in_retry),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_retry (out_retry)
);

// File: tb/parity_halve_stage_test.sv
module parity_halve_stage_test;
  localparam int unsigned W = 8;
  localparam int unsigned N = 1 << W;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic         in_retry;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_retry = 1'b0;

  int checks = 0;
  int errors = 0;

  int exp_q[$];
  int src_q[$];
  logic         last_acc;
  logic         stall_prev = 1'b0;
  logic [W-1:0] stall_data = '0;

  always #10 clk = ~clk;

  parity_halve_stage #(.W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_retry(in_retry), .out_valid(out_valid), .out_data(out_data),
    .out_retry(out_retry)
  );

  function automatic int model(input int v);
    return (v % 2 == 1) ? 0 : v / 2;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // sample after inputs have settled, ahead of the next rising edge
  task automatic observe();
    int e; int s;
    if (stall_prev)
      check(out_valid && out_data == stall_data, "R6", int'(out_data), int'(stall_data));
    if (out_valid && !out_retry) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", int'(out_data), -1);
      end else begin
        e = exp_q.pop_front();
        s = src_q.pop_front();
        check(int'(out_data) == e, (s % 2 == 1) ? "R3" : "R4", int'(out_data), e);
      end
    end
    last_acc = in_valid && !in_retry;
    if (last_acc) begin
      exp_q.push_back(model(int'(in_data)));
      src_q.push_back(int'(in_data));
    end
    stall_prev = out_valid && out_retry;
    stall_data = out_data;
  endtask

  task automatic step(input logic v, input logic [W-1:0] d, input logic r);
    @(negedge clk);
    in_valid = v; in_data = d; out_retry = r;
    #1;
    observe();
  endtask

  task automatic drain();
    for (int k = 0; k < 8; k++) step(1'b0, '0, 1'b0);
    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx; int retry_seen; logic pend; logic v; logic r;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    check(!out_valid, "R1", out_valid, 0);
    check(!in_retry, "R1", in_retry, 0);

    // R8: one even word into empty stage, visible the next cycle
    step(1'b1, 8'd6, 1'b1);
    check(last_acc, "R2", last_acc, 1);
    @(negedge clk); in_valid = 0; #1;
    check(out_valid && out_data == 8'd3, "R8", int'(out_data), 3);
    observe();
    step(1'b0, '0, 1'b0);
    drain();

    // R9: full sweep at full rate
    retry_seen = 0;
    for (int i = 0; i < N; i++) begin
      step(1'b1, i[W-1:0], 1'b0);
      if (in_retry) retry_seen++;
    end
    drain();
    check(retry_seen == 0, "R9", retry_seen, 0);

    // R7: long downstream stall, exactly two words get in
    step(1'b1, 8'd10, 1'b1);
    step(1'b1, 8'd11, 1'b1);
    check(!in_retry, "R7", in_retry, 0);
    step(1'b1, 8'd12, 1'b1);
    check(in_retry, "R7", in_retry, 1);
    for (int k = 0; k < 5; k++) step(1'b1, 8'd12, 1'b1);
    check(exp_q.size() == 2, "R7", exp_q.size(), 2);
    pend = 1'b1;
    while (pend) begin
      step(1'b1, 8'd12, 1'b0);
      pend = !last_acc;
    end
    drain();

    // R5: sweep under mixed valid/retry patterns, producer holds refused words
    idx = 0; pend = 1'b0;
    for (int c = 0; idx < N && c < 20000; c++) begin
      v = pend ? 1'b1 : ((c * 7) % 5 != 0);
      r = ((c * 3) % 7) < 3;
      step(v, idx[W-1:0], r);
      if (last_acc) idx++;
      pend = v && !last_acc;
    end
    check(idx == N, "R5", idx, N);
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule